// File: doc/BRIEF.md
# Interrupt Enable and Pending Flag Bank

This block gathers the interrupt sources of one peripheral into a single request line. It holds one enable bit and one pending flag for each source. Software never writes either register directly. Each register has a pair of write-only alias offsets, one that turns bits on and one that turns them off, so a driver changes only the bits it names and never needs a read-modify-write. A pending flag is raised by a one-cycle pulse on that source's event input. Software can also raise it through the flag-set alias to simulate a hardware event.

The request output is the OR, over all bit positions, of flag AND enable. It is registered, so it follows the state one clock later. The enable register and the flag register can both be read back on a small synchronous register bus. Read data is combinational from the current state and the address presented.

Top module: `irq_bank`

## Requirements
- R1: A write to byte offset 0x54 sets every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R2: A write to offset 0x58 clears every enable bit whose write-data bit is 1. The other enable bits keep their value.
- R3: Reading offset 0x68 returns the flag register, with bit i holding the flag of source i. Writes to 0x68 change neither register.
- R4: Flag bit i becomes 1 at a rising clock edge where `evt_i[i]` is 1, or where a write to offset 0x6C carries a 1 in data bit i.
- R5: A write to offset 0x70 clears every flag bit whose write-data bit is 1. The other flag bits keep their value.
- R6: At each rising edge, `irq_o` takes the value 1 exactly when some bit position had both its flag and its enable at 1 just before that edge. The output therefore lags the state by one clock.
- R7: While `rst_n` is low, and directly after it, all enable bits, all flag bits and `irq_o` are 0.
- R8: Reading offset 0x50 returns the enable register. Reads of 0x54, 0x58, 0x6C, 0x70 and any unmapped offset return 0. Writes to 0x50 or to unmapped offsets change nothing.
- R9: When a source's event and a flag-clear write naming that bit fall in the same cycle, the flag ends up set.
- R10: A flag may be pending while its enable is 0, and `irq_o` stays 0. Setting that enable later makes `irq_o` go to 1 one clock after the enable changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| evt_i | input | NSRC (32) | Per-source event pulses, one bit per source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A corrupted enable or flag bit shows up on `bus_rdata` in the same cycle that 0x50 or 0x68 is read. If that bit position is paired with a set partner bit, it also shows on `irq_o` one clock after the corruption. Because of this, the bench compares the read data on every cycle and the request on every edge against a bit-level model. A wrong set/clear priority, a missing event, or a write leaking into a read-only offset therefore appears within one to two clocks of the stimulus that exposes it. Directed steps cover the event-versus-clear collision, a flag pending behind a disabled enable, and writes to read-only and unmapped offsets.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    // Byte offsets; software drivers depend on these values
    localparam int unsigned OFS_EN_RD   = 32'h50;
    localparam int unsigned OFS_EN_SET  = 32'h54;
    localparam int unsigned OFS_EN_CLR  = 32'h58;
    localparam int unsigned OFS_FLG_RD  = 32'h68;
    localparam int unsigned OFS_FLG_SET = 32'h6C;
    localparam int unsigned OFS_FLG_CLR = 32'h70;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_EN_RD,
        ACC_EN_SET,
        ACC_EN_CLR,
        ACC_FLG_RD,
        ACC_FLG_SET,
        ACC_FLG_CLR
    } acc_e;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output acc_e              rd_kind,
    output acc_e              wr_kind
);

    acc_e kind;

    always_comb begin
        if      (addr == ADDR_W'(OFS_EN_RD))   kind = ACC_EN_RD;
        else if (addr == ADDR_W'(OFS_EN_SET))  kind = ACC_EN_SET;
        else if (addr == ADDR_W'(OFS_EN_CLR))  kind = ACC_EN_CLR;
        else if (addr == ADDR_W'(OFS_FLG_RD))  kind = ACC_FLG_RD;
        else if (addr == ADDR_W'(OFS_FLG_SET)) kind = ACC_FLG_SET;
        else if (addr == ADDR_W'(OFS_FLG_CLR)) kind = ACC_FLG_CLR;
        else                                   kind = ACC_NONE;
    end

    assign rd_kind = kind;
    // Only the four alias offsets accept writes
    always_comb begin
        wr_kind = ACC_NONE;
        if (we && (kind == ACC_EN_SET || kind == ACC_EN_CLR ||
                   kind == ACC_FLG_SET || kind == ACC_FLG_CLR))
            wr_kind = kind;
    end

endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
    import irq_bank_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  acc_e            wr_kind,
    input  logic [NSRC-1:0] wmask,
    input  logic [NSRC-1:0] evt,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] flag_q,
    output logic            irq_q
);

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flag;
        logic            irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (wr_kind)
            ACC_EN_SET:  st_d.en   = st_q.en | wmask;
            ACC_EN_CLR:  st_d.en   = st_q.en & ~wmask;
            ACC_FLG_SET: st_d.flag = st_q.flag | wmask;
            ACC_FLG_CLR: st_d.flag = st_q.flag & ~wmask;
            default: ;
        endcase
        // Hardware events are applied last so they override a clear
        st_d.flag = st_d.flag | evt;
        st_d.irq  = |(st_q.flag & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign flag_q = st_q.flag;
    assign irq_q  = st_q.irq;

endmodule

// File: rtl/irq_bank_rdmux.sv
module irq_bank_rdmux
    import irq_bank_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int DATA_W = 32
) (
    input  acc_e              rd_kind,
    input  logic [NSRC-1:0]   en_q,
    input  logic [NSRC-1:0]   flag_q,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        unique case (rd_kind)
            ACC_EN_RD:  rdata = DATA_W'(en_q);
            ACC_FLG_RD: rdata = DATA_W'(flag_q);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_bank.sv
module irq_bank
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NSRC   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   evt_i,
    output logic              irq_o
);

    acc_e            rd_kind;
    acc_e            wr_kind;
    logic [NSRC-1:0] wmask;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] flag_q;

    assign wmask = bus_wdata[NSRC-1:0];

    irq_bank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .we      (bus_we),
        .rd_kind (rd_kind),
        .wr_kind (wr_kind)
    );

    irq_bank_regs #(.NSRC(NSRC)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_kind (wr_kind),
        .wmask   (wmask),
        .evt     (evt_i),
        .en_q    (en_q),
        .flag_q  (flag_q),
        .irq_q   (irq_o)
    );

    irq_bank_rdmux #(.NSRC(NSRC), .DATA_W(DATA_W)) u_rd (
        .rd_kind (rd_kind),
        .en_q    (en_q),
        .flag_q  (flag_q),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NSRC   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NSRC-1:0]   evt_i,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   flag_q,
    input logic              irq_o
);

    logic [NSRC-1:0] wm;
    assign wm = bus_wdata[NSRC-1:0];

    AST_EN_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_EN_SET)) |=> ((en_q & $past(wm)) == $past(wm))); // R1

    AST_EN_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_EN_CLR)) |=> ((en_q & $past(wm)) == '0)); // R2

    AST_FLAG_ADDR_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_FLG_RD) && evt_i == '0) |=> (flag_q == $past(flag_q) && en_q == $past(en_q))); // R3

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i))); // R4 R9

    AST_FLG_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFS_FLG_CLR)) |=> ((flag_q & $past(wm) & ~$past(evt_i)) == '0)); // R5

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(flag_q & en_q)))); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (en_q == '0 && flag_q == '0 && !irq_o)); // R7

endmodule

bind irq_bank irq_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .evt_i     (evt_i),
    .en_q      (en_q),
    .flag_q    (flag_q),
    .irq_o     (irq_o)
);

// File: tb/irq_bank_test.sv
`timescale 1ns/1ps
module irq_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] evt_i = '0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] en_m = '0;
    logic [31:0] flag_m = '0;
    logic        irq_m = 1'b0;

    always #2 clk = ~clk;

    irq_bank uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_i     (evt_i),
        .irq_o     (irq_o)
    );

    function automatic logic [31:0] mread(input logic [7:0] a);
        if (a == 8'h50) return en_m;
        if (a == 8'h68) return flag_m;
        return 32'h0;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] w,
                        input logic [31:0] e, input string tag);
        string rt;
        string it;
        rt = (tag != "") ? tag : ((a == 8'h68) ? "R3" : "R8");
        it = (tag != "") ? tag : "R6";
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = w; evt_i = e;
        #1 check(bus_rdata, mread(a), rt, "read data");
        @(posedge clk);
        irq_m = |(flag_m & en_m);
        if (we && a == 8'h54) en_m = en_m | w;
        if (we && a == 8'h58) en_m = en_m & ~w;
        if (we && a == 8'h6C) flag_m = flag_m | w;
        if (we && a == 8'h70) flag_m = flag_m & ~w;
        flag_m = flag_m | e;
        #1 check({31'b0, irq_o}, {31'b0, irq_m}, it, "irq_o");
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0; evt_i = '0; bus_addr = 8'h50;
        en_m = '0; flag_m = '0; irq_m = 1'b0;
        #1 check({31'b0, irq_o}, 32'h0, "R7", "irq_o in reset");
        check(bus_rdata, 32'h0, "R7", "enable in reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R7: state after reset
        step(0, 8'h50, 0, 0, "R7");
        step(0, 8'h68, 0, 0, "R7");
        // R1: set enable bits, zero bits untouched
        step(1, 8'h54, 32'h3, 0, "R1");
        step(1, 8'h54, 32'hF0, 0, "R1");
        step(0, 8'h50, 0, 0, "R1");
        check(bus_rdata, 32'hF3, "R1", "enable after two sets");
        // R2: clear enable bits
        step(1, 8'h58, 32'h11, 0, "R2");
        step(0, 8'h50, 0, 0, "R2");
        check(bus_rdata, 32'hE2, "R2", "enable after clear");
        // R3: flag address is read-only
        step(1, 8'h68, 32'hFFFF_FFFF, 0, "R3");
        step(0, 8'h68, 0, 0, "R3");
        check(bus_rdata, 32'h0, "R3", "flags after write to read-only");
        // R8: enable readback ignores writes, aliases read zero
        step(1, 8'h50, 32'hFFFF, 0, "R8");
        step(1, 8'h04, 32'hFFFF, 0, "R8");
        step(0, 8'h50, 0, 0, "R8");
        check(bus_rdata, 32'hE2, "R8", "enable after ignored writes");
        step(0, 8'h54, 0, 0, "R8");
        step(0, 8'h70, 0, 0, "R8");
        // R4 software set; R10 pending flag with enable off
        step(1, 8'h6C, 32'h100, 0, "R4");
        step(0, 8'h68, 0, 0, "R4");
        check(bus_rdata, 32'h100, "R4", "flag after software set");
        step(0, 8'h68, 0, 0, "R10");
        check({31'b0, irq_o}, 32'h0, "R10", "irq with disabled pending flag");
        step(1, 8'h54, 32'h100, 0, "R10");
        step(0, 8'h50, 0, 0, "R10");
        check({31'b0, irq_o}, 32'h1, "R10", "irq after enabling pending flag");
        // R5: clear the flag, irq drops one clock later
        step(1, 8'h70, 32'h100, 0, "R5");
        step(0, 8'h68, 0, 0, "R5");
        check({31'b0, irq_o}, 32'h0, "R5", "irq after flag clear");
        // R9: event beats a same-cycle clear
        step(1, 8'h70, 32'h4, 32'h4, "R9");
        step(0, 8'h68, 0, 0, "R9");
        check(bus_rdata & 32'h4, 32'h4, "R9", "flag kept on collision");
        // R4 hardware event
        step(0, 8'h68, 0, 32'h8000_0000, "R4");
        step(0, 8'h68, 0, 0, "R4");
        check(bus_rdata & 32'h8000_0000, 32'h8000_0000, "R4", "flag from event");
        // Random traffic, R6 on every edge
        for (int i = 0; i < 3000; i++) begin
            logic [7:0]  a;
            logic [31:0] w;
            logic [31:0] e;
            case ($urandom_range(0, 6))
                0: a = 8'h50; 1: a = 8'h54; 2: a = 8'h58; 3: a = 8'h68;
                4: a = 8'h6C; 5: a = 8'h70; default: a = 8'h0C;
            endcase
            w = ($urandom_range(0, 1) == 0) ? $urandom() : ($urandom() & $urandom() & $urandom());
            e = ($urandom_range(0, 3) == 0) ? ($urandom() & $urandom() & $urandom() & $urandom()) : 32'h0;
            step(1'($urandom_range(0, 1)), a, w, e, "");
        end
        // R7: reset in the middle of activity
        step(1, 8'h54, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R7");
        do_reset();
        step(0, 8'h68, 0, 0, "R7");
        check(bus_rdata, 32'h0, "R7", "flags after second reset");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule